// File: doc/BRIEF.md
# Capture-Compare Timer Channel

This block is one timer channel with a 32-bit up-counter, a compare register and a capture register. The counter advances on one of three sources chosen in a mode register: every bus clock, one bus clock in sixteen, or each rising edge of an external pin. On every counter advance the block compares the new count with the compare register. When they are equal it pulses a match event, and it can also restart the count from zero. The same pin can instead act as a capture input. A chosen edge on the pin then copies the running count into the capture register and pulses a capture event.

Software reaches the channel through a small word-wide register port. Writes take effect on the clock edge that samples them. Reads are combinational and have no side effects. The pin passes through a synchroniser before its edges are detected. Because the pin cannot be a clock source and a capture input at the same time, the block suppresses capture while the pin is clocking the counter.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the mode register reads 0, the compare register reads 0xFFFFFFFF, the capture register and the counter read 0, and both event outputs are low.
- R2: The register slots are: address 0 mode, 1 compare, 2 capture, 3 counter. The mode word holds clock select in bits [1:0], capture edge in bits [3:2] and restart in bit 4. With clock select 00 the counter holds its value. With 01 it rises by one on every bus clock, starting on the second edge after the mode write.
- R3: With clock select 10 the counter rises once every 16 bus clocks. The first step lands on the 17th edge after the mode write.
- R4: With clock select 11 the counter rises once per rising edge of the pin, after synchronisation.
- R5: A write to the counter address sets the counter to zero at that edge, whatever data is written. This takes priority over an advance.
- R6: The edge field selects capture on rising (01), falling (10) or both (11) pin edges. The capture register takes the counter value present after the second clock edge that follows the pin change. The capture event pulses for one cycle in the cycle the new value appears.
- R7: Edge field 00 disables capture: pin edges change neither the capture register nor the capture event.
- R8: While clock select is 11, the capture register holds its value and no capture event is raised, whatever the edge field says.
- R9: The capture register is read-only; a write to address 2 leaves it unchanged.
- R10: The match event is high for exactly one cycle, in the cycle after an advance that makes the counter equal to the compare value.
- R11: With the restart bit set, an advance that reaches the compare value loads zero into the counter instead. The match event still pulses.
- R12: Reads are combinational and do not disturb counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 2 | Register slot select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected slot |
| pin_in | input | 1 | Asynchronous pin: count clock or capture input |
| match_evt | output | 1 | One-cycle compare match event |
| cap_evt | output | 1 | One-cycle capture event |

## Verification
The properties assume that the restart bit is not rewritten on the same edge as a match. They also assume that the counter is never written while the compare value equals one more than the count. The bench stops the channel before it reprograms the compare value or the mode. Every pin level is held for at least four bus clocks, so each pin change produces exactly one synchronised edge. The bench parks the address on the capture slot between transactions, which lets the scoreboard monitor read the captured value as soon as an event appears.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        CLK_STOP = 2'b00,
        CLK_BUS  = 2'b01,
        CLK_DIV  = 2'b10,
        CLK_PIN  = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } cap_edge_e;

    typedef struct packed {
        logic      restart;
        cap_edge_e edge_sel;
        clk_sel_e  clk_sel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        A_MODE = 2'd0,
        A_REF  = 2'd1,
        A_CAP  = 2'd2,
        A_CNT  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/cct_pin_edge.sv
module cct_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
    parameter int CNT_W       = 32,
    parameter int PRE_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             pin_in,
    output logic             match_evt,
    output logic             cap_evt
);
    import cct_pkg::*;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] ref_v;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] cnt;
        logic             match;
        logic             capev;
    } state_t;

    localparam state_t RESET_ST = '{
        mode:  '0,
        ref_v: '1,
        cap:   '0,
        cnt:   '0,
        match: 1'b0,
        capev: 1'b0
    };

    state_t st_d, st_q;

    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q, cap_q, cnt_q;
    assign mode_q = st_q.mode;
    assign ref_q  = st_q.ref_v;
    assign cap_q  = st_q.cap;
    assign cnt_q  = st_q.cnt;

    logic pre_tick, pin_rise, pin_fall;

    cct_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_q.clk_sel == CLK_DIV),
        .tick  (pre_tick)
    );

    cct_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    logic             adv;
    logic             cap_hit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        unique case (mode_q.clk_sel)
            CLK_BUS: adv = 1'b1;
            CLK_DIV: adv = pre_tick;
            CLK_PIN: adv = pin_rise;
            default: adv = 1'b0;
        endcase

        unique case (mode_q.edge_sel)
            EDGE_RISE: cap_hit = pin_rise;
            EDGE_FALL: cap_hit = pin_fall;
            EDGE_ANY:  cap_hit = pin_rise | pin_fall;
            default:   cap_hit = 1'b0;
        endcase
        // pin as count clock excludes it as capture input
        if (mode_q.clk_sel == CLK_PIN) cap_hit = 1'b0;

        cnt_inc = cnt_q + 1'b1;

        st_d       = st_q;
        st_d.match = 1'b0;
        st_d.capev = 1'b0;

        if (adv) begin
            if (cnt_inc == ref_q) begin
                st_d.match = 1'b1;
                st_d.cnt   = mode_q.restart ? '0 : cnt_inc;
            end else begin
                st_d.cnt   = cnt_inc;
            end
        end

        if (cap_hit) begin
            st_d.cap   = cnt_q;
            st_d.capev = 1'b1;
        end

        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                A_MODE: st_d.mode  = mode_t'(bus_wdata[MODE_W-1:0]);
                A_REF:  st_d.ref_v = bus_wdata;
                A_CNT: begin
                    st_d.cnt   = '0;
                    st_d.match = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            A_MODE: bus_rdata[MODE_W-1:0] = mode_q;
            A_REF:  bus_rdata = ref_q;
            A_CAP:  bus_rdata = cap_q;
            default: bus_rdata = cnt_q;
        endcase
    end

    assign match_evt = st_q.match;
    assign cap_evt   = st_q.capev;
endmodule

// File: rtl/cc_timer_chan_chk.sv
module cc_timer_chan_chk #(
    parameter int CNT_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [1:0]          bus_addr,
    input logic                match_evt,
    input logic                cap_evt,
    input cct_pkg::mode_t      mode_q,
    input logic [CNT_W-1:0]    ref_q,
    input logic [CNT_W-1:0]    cap_q,
    input logic [CNT_W-1:0]    cnt_q
);
    import cct_pkg::*;

    logic cnt_write;
    assign cnt_write = bus_wr && (bus_addr == A_CNT);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> (cnt_q == '0));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.clk_sel == CLK_STOP && !cnt_write) |=> $stable(cnt_q));

    // R8
    pin_clk_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.clk_sel == CLK_PIN) |=> !cap_evt);

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |-> $stable(cap_q));

    // R10
    match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> ((cnt_q == ref_q) || (mode_q.restart && cnt_q == '0)));

    // R10
    match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !mode_q.restart) |=> !match_evt);
endmodule

bind cc_timer_chan cc_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .match_evt (match_evt),
    .cap_evt   (cap_evt),
    .mode_q    (mode_q),
    .ref_q     (ref_q),
    .cap_q     (cap_q),
    .cnt_q     (cnt_q)
);

// File: tb/cc_timer_chan_bench.sv
module cc_timer_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pin_in;
    logic        match_evt;
    logic        cap_evt;

    int total = 0;
    int bad   = 0;
    int cap_seen = 0;
    logic [31:0] exp_cap[$];

    always #5 clk = ~clk;

    cc_timer_chan u_cc_timer_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .match_evt (match_evt),
        .cap_evt   (cap_evt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 2'd2;
    endtask

    // stop, clear, then program: counter equals k after k further negedges
    task automatic start_run(logic [4:0] m);
        wr(2'd0, 32'd0);
        wr(2'd3, 32'd0);
        wr(2'd0, {27'd0, m});
    endtask

    // scoreboard monitor for capture events (address parked on capture slot)
    always begin
        @(negedge clk);
        #2;
        if (rst_n === 1'b1 && cap_evt === 1'b1) begin
            cap_seen++;
            if (exp_cap.size() == 0) begin
                total++; bad++;
                $display("FAIL R7/R8 unexpected capture act=%h exp=none", bus_rdata);
            end else begin
                chk("R6 captured value", bus_rdata, exp_cap.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0; pin_in = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset values
        rd(2'd0, v); chk("R1 mode", v, 32'd0);
        rd(2'd1, v); chk("R1 compare", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 capture", v, 32'd0);
        rd(2'd3, v); chk("R1 counter", v, 32'd0);
        chk("R1 match_evt", {31'd0, match_evt}, 32'd0);
        chk("R1 cap_evt", {31'd0, cap_evt}, 32'd0);
        cyc(3);
        rd(2'd3, v); chk("R2 stopped after reset", v, 32'd0);

        // R2 bus/1 counting and stop hold; R12 reads do not disturb
        start_run(5'h01);
        cyc(3);
        rd(2'd3, v); rd(2'd3, v); chk("R12 repeated read", v, 32'd3);
        cyc(4);
        rd(2'd3, v); chk("R2 bus clock count", v, 32'd7);
        wr(2'd0, 32'd0);
        rd(2'd3, v); chk("R2 stop edge", v, 32'd8);
        cyc(5);
        rd(2'd3, v); chk("R2 stopped hold", v, 32'd8);

        // R5 clear regardless of data
        start_run(5'h01);
        cyc(4);
        rd(2'd3, v); chk("R5 before clear", v, 32'd4);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, v); chk("R5 cleared", v, 32'd0);
        cyc(1);
        rd(2'd3, v); chk("R5 resumes", v, 32'd1);

        // R3 divide by 16
        start_run(5'h02);
        cyc(15);
        rd(2'd3, v); chk("R3 before first step", v, 32'd0);
        cyc(1);
        rd(2'd3, v); chk("R3 first step", v, 32'd1);
        cyc(31);
        rd(2'd3, v); chk("R3 k=47", v, 32'd2);
        cyc(1);
        rd(2'd3, v); chk("R3 k=48", v, 32'd3);

        // R6 rising edge capture
        start_run(5'h05);
        cyc(5);  pin_in = 1'b1; exp_cap.push_back(32'd7);
        cyc(10); pin_in = 1'b0;
        cyc(10);
        rd(2'd2, v); chk("R6 rise capture reg", v, 32'd7);

        // R6 falling edge capture
        start_run(5'h09);
        cyc(3);  pin_in = 1'b1;
        cyc(10); pin_in = 1'b0; exp_cap.push_back(32'd15);
        cyc(10);
        rd(2'd2, v); chk("R6 fall capture reg", v, 32'd15);

        // R6 both edges
        start_run(5'h0D);
        cyc(4);  pin_in = 1'b1; exp_cap.push_back(32'd6);
        cyc(16); pin_in = 1'b0; exp_cap.push_back(32'd22);
        cyc(10);
        rd(2'd2, v); chk("R6 both capture reg", v, 32'd22);

        // R7 edge field off
        start_run(5'h01);
        cyc(2); pin_in = 1'b1;
        cyc(6); pin_in = 1'b0;
        cyc(6);
        rd(2'd2, v); chk("R7 capture held", v, 32'd22);

        // R4 pin as clock, R8 no capture in that mode
        start_run(5'h0F);
        for (int i = 0; i < 3; i++) begin
            cyc(4); pin_in = 1'b1;
            cyc(4); pin_in = 1'b0;
        end
        cyc(6);
        rd(2'd3, v); chk("R4 pin edge count", v, 32'd3);
        rd(2'd2, v); chk("R8 capture held", v, 32'd22);

        // R9 capture read-only
        wr(2'd2, 32'h0000_1234);
        rd(2'd2, v); chk("R9 write ignored", v, 32'd22);

        // R10 compare match without restart
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd10);
        start_run(5'h01);
        for (int k = 1; k <= 12; k++) begin
            cyc(1);
            rd(2'd3, v); chk("R10 count", v, k);
            chk("R10 match pulse", {31'd0, match_evt}, (k == 10) ? 32'd1 : 32'd0);
        end

        // R11 restart on match
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd5);
        start_run(5'h11);
        for (int k = 1; k <= 12; k++) begin
            cyc(1);
            rd(2'd3, v); chk("R11 wrapped count", v, k % 5);
            chk("R11 match pulse", {31'd0, match_evt}, (k % 5 == 0) ? 32'd1 : 32'd0);
        end
        wr(2'd0, 32'd0);
        cyc(4);

        chk("R6 pending captures", exp_cap.size(), 32'd0);
        chk("R6 capture events", cap_seen, 32'd4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule